// File: doc/BRIEF.md
# Saturating Digital Monitor Mixer

This block folds the captured stereo ADC stream back into the playback path. On each sample strobe it takes one captured stereo pair and scales it by a shared monitor attenuation. It adds the result to the incoming stereo playback pair and passes the clipped sum on to the DAC volume stage. All arithmetic is on 16-bit twos-complement linear samples. The host-bound capture data is taken before this block and is never altered by it.

Two service faults are handled with fixed rules. If the host has not taken the previous capture sample when a new strobe arrives (capture overrun), the mixer keeps using the last sample that was taken. If no fresh playback word is present at the strobe (playback underrun), the playback term becomes zero. The monitor path can also be switched off completely, and then only playback reaches the output.

Top module: `mon_mixer`

## Requirements
- R1: Each cycle with `smp_stb` high produces one output pair, registered on that clock edge, so `mix_vld` is high in exactly the following cycle. Between strobes, `mix_l`/`mix_r` keep their last value.
- R2: While reset is asserted, and after its release until the first strobe, `mix_l`, `mix_r` and `mix_vld` are zero and the held capture pair is zero.
- R3: The monitor code splits into a coarse part q = `mon_atten[5:2]` and a fine part f = `mon_atten[1:0]`. The attenuated sample is floor(x * M[f] / 2^(8+q)), with M = {256, 215, 181, 153} for f = 0..3. This gives steps of about 1.5 dB, and the same code applies to both channels.
- R4: With `mon_en` low, the monitor term is zero whatever the capture samples and code are.
- R5: The sum of the monitor term and the playback term is formed at 17 bits. It is clipped to +32767 or -32768 and never wraps.
- R6: A strobe with `cap_taken` high uses the new ADC pair as the monitor source and stores it. A strobe with `cap_taken` low (overrun) uses the stored pair instead. The stored pair is zero after reset.
- R7: A strobe with `ply_valid` low (underrun) uses zero in place of `ply_l`/`ply_r`.
- R8: At the deepest code, 63, the monitor term is floor(x*153/2^23). This gives 0 for any non-negative sample and -1 for any negative one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb | input | 1 | One-cycle sample strobe |
| adc_l | input | 16 | Captured left sample, signed |
| adc_r | input | 16 | Captured right sample, signed |
| cap_taken | input | 1 | Host took the previous capture sample |
| ply_l | input | 16 | Playback left sample, signed |
| ply_r | input | 16 | Playback right sample, signed |
| ply_valid | input | 1 | Playback pair is fresh for this strobe |
| mon_atten | input | 6 | Shared monitor attenuation code |
| mon_en | input | 1 | Monitor path enable |
| mix_l | output | 16 | Mixed left sample to DAC volume stage |
| mix_r | output | 16 | Mixed right sample to DAC volume stage |
| mix_vld | output | 1 | Mixed pair updated this cycle |

## Verification
The hardest case to reach is an overrun that replays a stored sample. The held pair is only visible when a later strobe arrives with `cap_taken` low, and the monitor path must be enabled at that moment. To reach it, the stimulus first loads a known pair into the hold while the monitor is muted, so the load leaves no trace at the output. The next strobe then turns the monitor on, clears `cap_taken` and presents a different ADC pair, so only the stored value can explain the output. Clipping at both rails and the deepest attenuation code, where negative samples floor to -1, are driven as separate vectors.

// File: rtl/mon_mixer_pkg.sv
package mon_mixer_pkg;
  localparam int MANT_W = 9;
  localparam int FRAC_W = 8;

  // fine-step gain in 1/256 units: 0, -1.5, -3, -4.5 dB
  function automatic logic [MANT_W-1:0] fine_gain(input logic [1:0] f);
    logic [MANT_W-1:0] g;
    case (f)
      2'd0:    g = 9'd256;
      2'd1:    g = 9'd215;
      2'd2:    g = 9'd181;
      default: g = 9'd153;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/mon_mixer_rst_sync.sv
module mon_mixer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stg_q, stg_d;
  logic out_q, out_d;

  always_comb begin
    stg_d = 1'b1;
    out_d = stg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      stg_q <= stg_d;
      out_q <= out_d;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/mon_mixer_atten.sv
module mon_mixer_atten
  import mon_mixer_pkg::*;
#(
  parameter int SW = 16,
  parameter int CW = 6
) (
  input  logic [CW-1:0]        code,
  input  logic signed [SW-1:0] smp_i,
  output logic signed [SW-1:0] att_o
);
  localparam int QW = CW - 2;
  localparam int PW = SW + MANT_W + 1;

  logic [QW-1:0]          coarse;
  logic [MANT_W-1:0]      gain;
  logic signed [PW-1:0]   prod;

  always_comb begin
    coarse = code[CW-1:2];
    gain   = fine_gain(code[1:0]);
    prod   = PW'(smp_i * $signed({1'b0, gain}));
    att_o  = SW'(prod >>> (FRAC_W + int'(coarse)));
  end
endmodule

// File: rtl/mon_mixer_satadd.sv
module mon_mixer_satadd #(
  parameter int SW = 16
) (
  input  logic signed [SW-1:0] a_i,
  input  logic signed [SW-1:0] b_i,
  output logic signed [SW-1:0] s_o
);
  logic signed [SW:0] wide;

  always_comb begin
    wide = {a_i[SW-1], a_i} + {b_i[SW-1], b_i};
    if (wide[SW] != wide[SW-1])
      s_o = wide[SW] ? {1'b1, {(SW-1){1'b0}}} : {1'b0, {(SW-1){1'b1}}};
    else
      s_o = wide[SW-1:0];
  end
endmodule

// File: rtl/mon_mixer.sv
module mon_mixer #(
  parameter int SW = 16,
  parameter int CW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [SW-1:0] adc_l,
  input  logic signed [SW-1:0] adc_r,
  input  logic                 cap_taken,
  input  logic signed [SW-1:0] ply_l,
  input  logic signed [SW-1:0] ply_r,
  input  logic                 ply_valid,
  input  logic [CW-1:0]        mon_atten,
  input  logic                 mon_en,
  output logic signed [SW-1:0] mix_l,
  output logic signed [SW-1:0] mix_r,
  output logic                 mix_vld
);
  localparam int NCH = 2;

  logic rst_sync_n;

  mon_mixer_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic signed [SW-1:0] adc_v  [NCH];
  logic signed [SW-1:0] ply_v  [NCH];
  logic signed [SW-1:0] hold_q [NCH];
  logic signed [SW-1:0] hold_d [NCH];
  logic signed [SW-1:0] src    [NCH];
  logic signed [SW-1:0] mon    [NCH];
  logic signed [SW-1:0] pterm  [NCH];
  logic signed [SW-1:0] sum    [NCH];
  logic signed [SW-1:0] out_q  [NCH];
  logic signed [SW-1:0] out_d  [NCH];
  logic                 hold_en;
  logic                 vld_q, vld_d;

  assign adc_v[0] = adc_l;
  assign adc_v[1] = adc_r;
  assign ply_v[0] = ply_l;
  assign ply_v[1] = ply_r;
  assign hold_en  = smp_stb & cap_taken;
  assign vld_d    = smp_stb;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    // monitor source: fresh sample when consumed, stored one on overrun
    always_comb begin
      src[ch]    = cap_taken ? adc_v[ch] : hold_q[ch];
      hold_d[ch] = hold_en ? adc_v[ch] : hold_q[ch];
      pterm[ch]  = ply_valid ? ply_v[ch] : '0;
    end

    logic signed [SW-1:0] att;

    mon_mixer_atten #(.SW(SW), .CW(CW)) u_att (
      .code  (mon_atten),
      .smp_i (src[ch]),
      .att_o (att)
    );

    assign mon[ch] = mon_en ? att : '0;

    mon_mixer_satadd #(.SW(SW)) u_add (
      .a_i (mon[ch]),
      .b_i (pterm[ch]),
      .s_o (sum[ch])
    );

    assign out_d[ch] = smp_stb ? sum[ch] : out_q[ch];

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        hold_q[ch] <= '0;
        out_q[ch]  <= '0;
      end else begin
        hold_q[ch] <= hold_d[ch];
        out_q[ch]  <= out_d[ch];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= vld_d;
  end

  assign mix_l   = out_q[0];
  assign mix_r   = out_q[1];
  assign mix_vld = vld_q;
endmodule

// File: rtl/mon_mixer_chk.sv
module mon_mixer_chk #(
  parameter int SW = 16,
  parameter int CW = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_stb,
  input logic signed [SW-1:0] adc_l,
  input logic                 cap_taken,
  input logic signed [SW-1:0] ply_l,
  input logic                 ply_valid,
  input logic [CW-1:0]        mon_atten,
  input logic                 mon_en,
  input logic signed [SW-1:0] mix_l,
  input logic signed [SW-1:0] mix_r,
  input logic                 mix_vld
);
  assert_vld_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> mix_vld);

  assert_vld_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> (!mix_vld && $stable(mix_l) && $stable(mix_r)));

  assert_unity_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && mon_en && cap_taken && !ply_valid && mon_atten == '0)
      |=> mix_l == $past(adc_l));

  assert_mute_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !mon_en && !ply_valid) |=> (mix_l == '0 && mix_r == '0));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && mon_en && ply_valid && cap_taken && mon_atten == '0 &&
     adc_l > 0 && ply_l > 0) |=> mix_l > 0);

  assert_play_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !mon_en && ply_valid) |=> mix_l == $past(ply_l));
endmodule

bind mon_mixer mon_mixer_chk #(.SW(SW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .smp_stb   (smp_stb),
  .adc_l     (adc_l),
  .cap_taken (cap_taken),
  .ply_l     (ply_l),
  .ply_valid (ply_valid),
  .mon_atten (mon_atten),
  .mon_en    (mon_en),
  .mix_l     (mix_l),
  .mix_r     (mix_r),
  .mix_vld   (mix_vld)
);

// File: tb/mon_mixer_tb.sv
`timescale 1ns/1ps
module mon_mixer_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic smp_stb, cap_taken, ply_valid, mon_en;
  logic signed [15:0] adc_l, adc_r, ply_l, ply_r;
  logic [5:0] mon_atten;
  logic signed [15:0] mix_l, mix_r;
  logic mix_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int hold_l = 0, hold_r = 0;

  always #2 clk = ~clk;

  mon_mixer u_dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .adc_l(adc_l), .adc_r(adc_r), .cap_taken(cap_taken),
    .ply_l(ply_l), .ply_r(ply_r), .ply_valid(ply_valid),
    .mon_atten(mon_atten), .mon_en(mon_en),
    .mix_l(mix_l), .mix_r(mix_r), .mix_vld(mix_vld)
  );

  typedef struct packed {
    logic signed [15:0] al;
    logic signed [15:0] ar;
    logic signed [15:0] pl;
    logic signed [15:0] pr;
    logic pv;
    logic ct;
    logic en;
    logic [5:0] code;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{16'sd1000,   -16'sd2000,  16'sd500,   16'sd500,    1'b1, 1'b1, 1'b1, 6'd0},
    '{16'sd1001,   -16'sd1001,  16'sd0,     16'sd0,      1'b1, 1'b1, 1'b1, 6'd4},
    '{16'sd8000,   -16'sd8000,  16'sd100,   -16'sd100,   1'b1, 1'b1, 1'b1, 6'd1},
    '{16'sd20000,  -16'sd20000, 16'sd20000, -16'sd20000, 1'b1, 1'b1, 1'b1, 6'd0},
    '{16'sd300,    16'sd301,    16'sd12345, 16'sd12345,  1'b0, 1'b1, 1'b1, 6'd2},
    '{16'sd32767,  -16'sd32768, 16'sd77,    -16'sd77,    1'b1, 1'b1, 1'b0, 6'd0},
    '{16'sd9999,   16'sd9999,   16'sd0,     16'sd0,      1'b1, 1'b0, 1'b1, 6'd8},
    '{16'sd32767,  -16'sd32768, 16'sd10,    16'sd10,     1'b1, 1'b1, 1'b1, 6'd63},
    '{16'sd5000,   16'sd5000,   16'sd4000,  16'sd4000,   1'b0, 1'b1, 1'b0, 6'd3},
    '{-16'sd12000, 16'sd7000,   -16'sd3000, 16'sd3000,   1'b1, 1'b1, 1'b1, 6'd30}
  };

  function automatic int gain_of(input int f);
    case (f)
      0: return 256;
      1: return 215;
      2: return 181;
      default: return 153;
    endcase
  endfunction

  function automatic int atten(input int x, input int code);
    longint p;
    p = longint'(x) * gain_of(code % 4);
    return int'(p >>> (8 + code / 4));
  endfunction

  function automatic int clip(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input string req);
    int sl, sr, el, er;
    @(negedge clk);
    adc_l = v.al; adc_r = v.ar; ply_l = v.pl; ply_r = v.pr;
    ply_valid = v.pv; cap_taken = v.ct; mon_en = v.en; mon_atten = v.code;
    smp_stb = 1'b1;
    sl = v.ct ? int'(v.al) : hold_l;
    sr = v.ct ? int'(v.ar) : hold_r;
    if (v.ct) begin hold_l = v.al; hold_r = v.ar; end
    el = clip((v.en ? atten(sl, v.code) : 0) + (v.pv ? int'(v.pl) : 0));
    er = clip((v.en ? atten(sr, v.code) : 0) + (v.pv ? int'(v.pr) : 0));
    @(negedge clk);
    smp_stb = 1'b0;
    adc_l = 16'sd1111; adc_r = -16'sd1111; ply_l = 16'sd2222; ply_r = 16'sd2222;
    check({req, " valid R1"}, int'(mix_vld), 1);
    check({req, " left"}, int'(mix_l), el);
    check({req, " right"}, int'(mix_r), er);
    @(negedge clk);
    check({req, " hold R1"}, int'(mix_vld), 0);
    check({req, " held left R1"}, int'(mix_l), el);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_stb = 1'b0; cap_taken = 1'b0; ply_valid = 1'b0;
    mon_en = 1'b0; mon_atten = '0;
    adc_l = '0; adc_r = '0; ply_l = '0; ply_r = '0;
    repeat (3) @(negedge clk);
    check("R2 reset vld", int'(mix_vld), 0);
    check("R2 reset left", int'(mix_l), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 post-release right", int'(mix_r), 0);
    check("R2 post-release vld", int'(mix_vld), 0);

    // R6: overrun right after reset replays the zero hold
    apply('{16'sd4000, 16'sd4000, 16'sd100, -16'sd100, 1'b1, 1'b0, 1'b1, 6'd0},
          "R6 zero hold");

    for (int i = 0; i < NV; i++) begin
      string tag;
      case (i)
        0: tag = "R3 unity";
        1: tag = "R3 coarse step";
        2: tag = "R3 fine step";
        3: tag = "R5 clip both rails";
        4: tag = "R7 underrun";
        5: tag = "R4 mute";
        6: tag = "R6 overrun replay";
        7: tag = "R8 deepest code";
        8: tag = "R4 R7 mute and underrun";
        default: tag = "R3 mid code";
      endcase
      apply(VEC[i], tag);
    end

    // directed: R5 exact rails, R8 exact values
    apply('{16'sd32767, -16'sd32768, 16'sd1, -16'sd1, 1'b1, 1'b1, 1'b1, 6'd0},
          "R5 rail by one");
    check("R5 pos rail", int'(mix_l), 32767);
    apply('{16'sd32767, -16'sd5, 16'sd0, 16'sd0, 1'b1, 1'b1, 1'b1, 6'd63},
          "R8 floor");
    check("R8 positive to zero", int'(mix_l), 0);
    check("R8 negative to minus one", int'(mix_r), -1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule